// File: doc/BRIEF.md
# Single-Precision Minimum/Maximum Unit

This unit takes two binary32 operands and returns whichever is smaller or larger, chosen by a one-bit select. The result appears in a register one clock after an input strobe, together with its own strobe, so the unit can sit as one stage of an arithmetic pipeline.

The ordering is total over non-NaN values: negative zero ranks below positive zero, infinities sit at the two ends, and subnormals are compared bit for bit without being flushed. NaN inputs are handled by preferring numbers. A lone NaN operand is dropped in favour of the other operand. When both operands are NaN, one fixed quiet pattern is produced. Signaling NaNs get no special treatment and nothing is flagged, because the unit has no exception output at all.

Top module: `fp32_minmax`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle in which `in_valid` was sampled high, and low after a cycle in which it was sampled low.
- R2: If exactly one operand is a NaN (exponent field all ones, fraction nonzero), the result is the other operand unchanged, whether `sel_max` is 0 or 1.
- R3: If both operands are NaN, the result is 32'h7FFFFFFF for either operation.
- R4: A signaling NaN (fraction MSB bit 22 clear, fraction nonzero) follows exactly the same rules as a quiet NaN.
- R5: Negative zero (32'h80000000) ranks below positive zero (32'h00000000). The minimum of the pair is 32'h80000000 and the maximum is 32'h00000000.
- R6: Non-NaN operands are ordered by sign and then magnitude. Among negatives, a larger magnitude is smaller. Infinities are the extremes, and subnormals are compared exactly. `sel_max`=0 returns the smaller operand and `sel_max`=1 returns the larger.
- R7: Unless both operands are NaN, the result is bit-identical to one of the two operands.
- R8: While `in_valid` is low, `result` keeps its previous value.
- R9: During reset, `result` is 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and select are valid this cycle |
| sel_max | input | 1 | 0 selects minimum, 1 selects maximum |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | Result register holds a new value |
| result | output | 32 | Registered minimum or maximum |

## Verification
Some properties are checked on every cycle by the embedded assertions:
- the strobe delay;
- holding the result while idle;
- the canonical pattern for two NaNs;
- passing through the non-NaN operand;
- the result always being one of the inputs;
- the signed-zero pair.

Whether the chosen operand is really the smaller or the larger one cannot be seen by those properties. The bench sweeps every pair from a set of edge values under both operations, then runs a long pseudo-random stream. It computes each expected result with an unsigned key ordering that is independent of the design's comparator.

// File: rtl/fp32_minmax.sv
`timescale 1ns/1ps
module fp32_minmax #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   sel_max,
  input  logic [EXP_W+MAN_W:0]   op_a,
  input  logic [EXP_W+MAN_W:0]   op_b,
  output logic                   out_valid,
  output logic [EXP_W+MAN_W:0]   result
);
  localparam int SGN = EXP_W + MAN_W;
  localparam logic [SGN:0] CANON_NAN = {1'b0, {SGN{1'b1}}};

  wire a_nan = (&op_a[SGN-1:MAN_W]) && (|op_a[MAN_W-1:0]);
  wire b_nan = (&op_b[SGN-1:MAN_W]) && (|op_b[MAN_W-1:0]);

  logic a_lt_b;
  always_comb begin
    if (op_a[SGN] != op_b[SGN])
      a_lt_b = op_a[SGN];
    else if (op_a[SGN])
      a_lt_b = op_a[SGN-1:0] > op_b[SGN-1:0];
    else
      a_lt_b = op_a[SGN-1:0] < op_b[SGN-1:0];
  end

  wire pick_b = sel_max ? a_lt_b : !a_lt_b;

  logic [SGN:0] nxt;
  always_comb begin
    if (a_nan && b_nan) nxt = CANON_NAN;
    else if (a_nan)     nxt = op_b;
    else if (b_nan)     nxt = op_a;
    else if (pick_b)    nxt = op_b;
    else                nxt = op_a;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  p_valid_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_one_nan_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_nan && !b_nan) |=> result == $past(op_b));
  p_one_nan_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && b_nan && !a_nan) |=> result == $past(op_a));
  p_both_nan_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_nan && b_nan) |=> result == CANON_NAN);
  p_zero_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_a == {1'b1, {SGN{1'b0}}} && op_b == '0) |=>
      result == ($past(sel_max) ? '0 : {1'b1, {SGN{1'b0}}}));
  p_member_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(a_nan && b_nan)) |=>
      (result == $past(op_a) || result == $past(op_b)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
endmodule

// File: tb/test_fp32_minmax.sv
`timescale 1ns/1ps
module test_fp32_minmax;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic sel_max = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic out_valid;
  logic [31:0] result;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fp32_minmax i_fp32_minmax (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_max(sel_max),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result));

  function automatic bit is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic logic [31:0] okey(input logic [31:0] x);
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b, input bit mx);
    if (is_nan(a) && is_nan(b)) return 32'h7FFF_FFFF;
    if (is_nan(a)) return b;
    if (is_nan(b)) return a;
    if (mx) return (okey(a) >= okey(b)) ? a : b;
    return (okey(a) <= okey(b)) ? a : b;
  endfunction

  function automatic string tag(input logic [31:0] a, input logic [31:0] b);
    bit sn = (is_nan(a) && !a[22]) || (is_nan(b) && !b[22]);
    if (sn) return "R4";
    if (is_nan(a) && is_nan(b)) return "R3";
    if (is_nan(a) || is_nan(b)) return "R2";
    if ((a[30:0] == 0) && (b[30:0] == 0)) return "R5";
    return "R6/R7";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit mx);
    op_a = a; op_b = b; sel_max = mx; in_valid = 1'b1;
    @(negedge clk);
    check("R1", {31'b0, out_valid}, 32'd1);
    check(tag(a, b), result, model(a, b, mx));
  endtask

  logic [31:0] vals [20];

  initial begin
    vals[0]  = 32'h0000_0000; vals[1]  = 32'h8000_0000;
    vals[2]  = 32'h7F80_0000; vals[3]  = 32'hFF80_0000;
    vals[4]  = 32'h7FC0_0000; vals[5]  = 32'h7F80_0001;
    vals[6]  = 32'hFFC0_0001; vals[7]  = 32'hFF80_0005;
    vals[8]  = 32'h0000_0001; vals[9]  = 32'h807F_FFFF;
    vals[10] = 32'h007F_FFFF; vals[11] = 32'h8000_0001;
    vals[12] = 32'h3F80_0000; vals[13] = 32'hBF80_0000;
    vals[14] = 32'h7F7F_FFFF; vals[15] = 32'hFF7F_FFFF;
    vals[16] = 32'h0080_0000; vals[17] = 32'h4049_0FDB;
    vals[18] = 32'hC049_0FDB; vals[19] = 32'hC000_0000;

    repeat (3) @(negedge clk);
    check("R9", result, 32'h0);
    check("R9", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 20; i++)
      for (int j = 0; j < 20; j++)
        for (int m = 0; m < 2; m++)
          run_op(vals[i], vals[j], m[0]);

    begin
      logic [31:0] s = 32'h1234_5678;
      logic [31:0] ra, rb;
      for (int k = 0; k < 3000; k++) begin
        s = s * 32'd1664525 + 32'd1013904223; ra = s;
        s = s * 32'd1664525 + 32'd1013904223; rb = s;
        if (k % 4 == 0) rb = {~ra[31], rb[30:0]};
        if (k % 7 == 0) rb = {ra[31], ra[30:0] ^ 31'h1};
        run_op(ra, rb, s[3]);
      end
    end

    begin
      logic [31:0] held;
      run_op(32'hBF80_0000, 32'h3F80_0000, 1'b0);
      held = result;
      in_valid = 1'b0; op_a = 32'h7F80_0000; op_b = 32'h7FC0_0000; sel_max = 1'b1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check("R8", result, held);
        check("R1", {31'b0, out_valid}, 32'd0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule